// File: doc/BRIEF.md
# Double-Buffered Serial Byte Transmitter

This block sends bytes over an asynchronous serial line. Each frame carries one low start bit, eight data bits sent least significant bit first, and one high stop bit. A holding register sits in front of the shift register. Software can therefore queue the next byte while the current frame is still on the line. When the queued byte is ready, it starts straight after the running stop bit and leaves no idle gap.

The bit rate is set from outside by a one-cycle baud tick enable. Every bit of a frame lasts from one tick to the next. A frame can only start on a tick. The interface works like a register: a write strobe loads the holding register, and two flags report its state. One flag says a byte is waiting. The other says the transmitter is busy. A one-cycle interrupt pulse marks each move of the holding register into the shift register, which is the moment the byte starts going out. An enable input gates the start of every frame.

Top module: `serial_tx_dbuf`

## Requirements
- R1: While reset (synchronous, active high) is applied, and on the first cycle after it, the serial line is high and the waiting flag, busy flag and interrupt output are all 0.
- R2: A write sets the waiting flag to 1 in the cycle after the write strobe.
- R3: A frame starts on a tick edge where a byte is waiting and the enable is 1. That edge is either at idle or at the end of a stop bit. After it, the line is low (start bit), the busy flag is 1 and the waiting flag is 0. The interrupt output is 1 for that one cycle only, so there is exactly one interrupt pulse per frame.
- R4: The line changes only on tick edges. After the start bit come data bits 0 to 7 in that order, one tick period each, then a stop bit driven high.
- R5: A byte written while a frame is running has its start bit on the tick that ends the current stop bit. There is no idle bit time between the two frames.
- R6: If no byte is waiting when a stop bit ends, the busy flag drops to 0 and the line stays high.
- R7: While the enable is 0, no frame starts and a waiting byte stays waiting. If the enable is cleared during a frame, that frame completes and no further frame starts.
- R8: A write while the waiting flag is 1 replaces the waiting byte and leaves both flags unchanged. Only the newest byte is sent.
- R9: A write in the same cycle as a frame start puts the new byte in the holding register. The frame carries the previously waiting byte, and the waiting flag stays 1 for the new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| txEnable | input | 1 | Allows frames to start |
| baudTick | input | 1 | One-cycle bit-rate enable |
| bufWrite | input | 1 | Write strobe for the holding register |
| bufData | input | 8 | Byte to queue |
| txLine | output | 1 | Serial output, idles high |
| bufFull | output | 1 | A byte is waiting in the holding register |
| txBusy | output | 1 | A frame is on the line |
| txIrq | output | 1 | One-cycle pulse when a byte moves into the shift register |

## Verification
The bench decodes the line at every tick. It watches for three faults: a frame that has an extra idle bit between queued bytes, a line that moves between ticks, and data sent in the wrong bit order. It also goes after the writes that are easy to get wrong. A write that lands on the same edge as a frame start must not be lost or sent twice. An overwrite of a waiting byte must send only the newest byte. A byte written while the enable is 0 must stay waiting and not leak out. The bench counts interrupt pulses against frames, so a level-style or doubled interrupt shows up as a count mismatch.

// File: rtl/serial_tx_pkg.sv
package serial_tx_pkg;
  typedef struct packed {
    logic load;    // holding register -> shift register, start bit
    logic shift;   // advance to next bit of the frame
    logic finish;  // frame over, return line to idle
  } txStrobe_t;
endpackage

// File: rtl/serial_tx_ctrl.sv
module serial_tx_ctrl
  import serial_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      txEnable,
  input  logic      baudTick,
  input  logic      bufWrite,
  output txStrobe_t strobe,
  output logic      bufFull,
  output logic      txBusy,
  output logic      txIrq
);
  localparam int FRAME_BITS = DATA_BITS + 2;
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(FRAME_BITS - 1);

  logic [CNT_W-1:0] bitPos;
  logic             startOk;

  assign startOk = bufFull && txEnable;

  always_comb begin
    strobe = '0;
    if (baudTick) begin
      if (!txBusy) begin
        strobe.load = startOk;
      end else if (bitPos != LAST_POS) begin
        strobe.shift = 1'b1;
      end else if (startOk) begin
        strobe.load = 1'b1;
      end else begin
        strobe.finish = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bufFull <= 1'b0;
      txBusy  <= 1'b0;
      txIrq   <= 1'b0;
      bitPos  <= '0;
    end else begin
      txIrq <= strobe.load;
      if (bufWrite)         bufFull <= 1'b1;
      else if (strobe.load) bufFull <= 1'b0;
      if (strobe.load) begin
        txBusy <= 1'b1;
        bitPos <= '0;
      end else if (strobe.shift) begin
        bitPos <= bitPos + 1'b1;
      end else if (strobe.finish) begin
        txBusy <= 1'b0;
      end
    end
  end

  // R2: a write always leaves a byte waiting
  p_write_sets_full_r2: assert property (@(posedge clk) disable iff (rst)
    bufWrite |=> bufFull);
  // R3: interrupt is a single-cycle pulse
  p_irq_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    txIrq |=> !txIrq);
  // R3: leaving idle is always announced by the interrupt
  p_busy_rise_irq_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(txBusy) |-> txIrq);
  // R7: no frame starts while disabled
  p_no_start_disabled_r7: assert property (@(posedge clk) disable iff (rst)
    !txEnable |=> !txIrq);
  // R7: disabled idle stays idle
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!txBusy && !txEnable) |=> !txBusy);
endmodule

// File: rtl/serial_tx_dpath.sv
module serial_tx_dpath
  import serial_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bufWrite,
  input  logic [DATA_BITS-1:0] bufData,
  input  txStrobe_t            strobe,
  output logic                 txLine
);
  logic [DATA_BITS-1:0] holdReg;
  logic [DATA_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      holdReg <= '0;
    end else if (bufWrite) begin
      holdReg <= bufData;
    end
  end

  // ones shift in from the top so the stop bit falls out after the data
  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '1;
      txLine   <= 1'b1;
    end else if (strobe.load) begin
      shiftReg <= holdReg;
      txLine   <= 1'b0;
    end else if (strobe.shift) begin
      shiftReg <= {1'b1, shiftReg[DATA_BITS-1:1]};
      txLine   <= shiftReg[0];
    end else if (strobe.finish) begin
      txLine   <= 1'b1;
    end
  end

  // R4: control never issues two strobes at once
  p_strobe_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strobe.load, strobe.shift, strobe.finish}));
  // R3: a frame start drives the start bit low
  p_start_low_r3: assert property (@(posedge clk) disable iff (rst)
    strobe.load |=> !txLine);
  // R6: ending a frame leaves the line high
  p_finish_high_r6: assert property (@(posedge clk) disable iff (rst)
    strobe.finish |=> txLine);
  // R4: line moves only on a strobe
  p_line_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !(strobe.load || strobe.shift || strobe.finish) |=> $stable(txLine));
endmodule

// File: rtl/serial_tx_dbuf.sv
module serial_tx_dbuf
  import serial_tx_pkg::*;
#(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 txEnable,
  input  logic                 baudTick,
  input  logic                 bufWrite,
  input  logic [DATA_BITS-1:0] bufData,
  output logic                 txLine,
  output logic                 bufFull,
  output logic                 txBusy,
  output logic                 txIrq
);
  txStrobe_t strobe;

  serial_tx_ctrl #(.DATA_BITS(DATA_BITS)) i_ctrl (
    .clk(clk), .rst(rst), .txEnable(txEnable), .baudTick(baudTick),
    .bufWrite(bufWrite), .strobe(strobe), .bufFull(bufFull),
    .txBusy(txBusy), .txIrq(txIrq)
  );

  serial_tx_dpath #(.DATA_BITS(DATA_BITS)) i_dpath (
    .clk(clk), .rst(rst), .bufWrite(bufWrite), .bufData(bufData),
    .strobe(strobe), .txLine(txLine)
  );

  // R6: an idle transmitter holds the line high
  p_idle_line_high_r6: assert property (@(posedge clk) disable iff (rst)
    !txBusy |-> txLine);
endmodule

// File: tb/test_serial_tx_dbuf.sv
module test_serial_tx_dbuf;
  localparam int CLK_PERIOD = 10;
  localparam int TICKDIV = 4;
  localparam int N_RANDOM = 40;

  logic clk = 0, rst = 1, txEnable = 0, bufWrite = 0;
  logic genTick = 0, forceTick = 0, baudTick, tickQ = 0;
  logic [7:0] bufData = 0;
  logic txLine, bufFull, txBusy, txIrq;
  logic tickOn = 0;
  int tickDiv = 0;
  int checks = 0, errors = 0;
  int rxCount = 0, irqCount = 0, idleRun = 0, lastGap = -1;
  int rxIdx = -1;
  logic [7:0] rxByte = 0;
  logic prevLine = 1;
  logic [7:0] expQ[$];
  bit done = 0;

  assign baudTick = genTick | forceTick;
  always #(CLK_PERIOD/2) clk = ~clk;

  serial_tx_dbuf i_serial_tx_dbuf (
    .clk(clk), .rst(rst), .txEnable(txEnable), .baudTick(baudTick),
    .bufWrite(bufWrite), .bufData(bufData), .txLine(txLine),
    .bufFull(bufFull), .txBusy(txBusy), .txIrq(txIrq)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit expectByte(input logic [7:0] b);
    return 1'b1;
  endfunction

  always @(negedge clk) begin
    if (tickOn) begin
      genTick <= (tickDiv == TICKDIV-1);
      tickDiv <= (tickDiv == TICKDIV-1) ? 0 : tickDiv + 1;
    end else begin
      genTick <= 1'b0;
    end
  end

  always @(posedge clk) tickQ <= baudTick;

  // line decoder, sampled at the negedge after each tick edge
  always @(negedge clk) begin
    if (!rst) begin
      if (txIrq) irqCount++;
      if (!tickQ && txLine !== prevLine)
        check(0, "R4 line moved between ticks", txLine, prevLine);
      if (tickQ) begin
        if (rxIdx < 0) begin
          if (txLine == 1'b0) begin
            lastGap = idleRun; idleRun = 0; rxIdx = 0;
          end else idleRun++;
        end else if (rxIdx < 8) begin
          rxByte[rxIdx] = txLine; rxIdx++;
        end else begin
          check(txLine == 1'b1, "R4 stop bit", txLine, 1);
          if (expQ.size() == 0) check(0, "R7 unexpected frame", rxByte, -1);
          else begin
            logic [7:0] e;
            e = expQ.pop_front();
            check(rxByte == e, "R4 received byte", rxByte, e);
          end
          rxCount++; rxIdx = -1;
        end
      end
      prevLine = txLine;
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic writeByte(input logic [7:0] d);
    @(negedge clk); bufWrite = 1; bufData = d;
    @(negedge clk); bufWrite = 0;
  endtask

  task automatic waitRx(input int n);
    while (rxCount < n) @(negedge clk);
  endtask

  task automatic waitIdle();
    while (txBusy || rxIdx >= 0) @(negedge clk);
  endtask

  initial begin
    int base;
    cyc(3);
    check(txLine == 1 && !bufFull && !txBusy && !txIrq, "R1 in reset", {txLine,bufFull,txBusy,txIrq}, 4'b1000);
    @(negedge clk); rst = 0;
    @(negedge clk);
    check(txLine == 1 && !bufFull && !txBusy && !txIrq, "R1 after reset", {txLine,bufFull,txBusy,txIrq}, 4'b1000);

    // R2/R3 single tick start
    txEnable = 1;
    writeByte(8'hA5); expQ.push_back(8'hA5);
    check(bufFull == 1, "R2 full after write", bufFull, 1);
    check(txBusy == 0, "R2 not busy without tick", txBusy, 0);
    forceTick = 1; @(negedge clk); forceTick = 0;
    check(txIrq == 1, "R3 irq at load", txIrq, 1);
    check(bufFull == 0, "R3 full cleared at load", bufFull, 0);
    check(txBusy == 1, "R3 busy at load", txBusy, 1);
    check(txLine == 0, "R3 start bit low", txLine, 0);
    @(negedge clk);
    check(txIrq == 0, "R3 irq one cycle", txIrq, 0);
    tickOn = 1;
    waitRx(1);

    // R6 idle after frame
    cyc(3*TICKDIV);
    check(txBusy == 0, "R6 busy cleared", txBusy, 0);
    check(txLine == 1, "R6 line high", txLine, 1);

    // R5 back to back
    writeByte(8'h3C); expQ.push_back(8'h3C);
    while (bufFull) @(negedge clk);
    writeByte(8'hC3); expQ.push_back(8'hC3);
    waitRx(3);
    check(lastGap == 0, "R5 no idle gap", lastGap, 0);
    waitIdle();

    // R7 disabled start, R8 overwrite
    txEnable = 0;
    base = rxCount;
    writeByte(8'h11);
    cyc(12*TICKDIV);
    check(txBusy == 0, "R7 no start while disabled", txBusy, 0);
    check(bufFull == 1, "R7 byte still waiting", bufFull, 1);
    check(txLine == 1, "R7 line idle", txLine, 1);
    writeByte(8'h96); expQ.push_back(8'h96);
    check(bufFull == 1 && txBusy == 0, "R8 flags unchanged on overwrite", {bufFull,txBusy}, 2'b10);
    txEnable = 1;
    waitRx(base + 1);
    waitIdle();

    // R7 mid-frame disable
    base = rxCount;
    writeByte(8'h5A); expQ.push_back(8'h5A);
    while (!txBusy) @(negedge clk);
    writeByte(8'h81);
    txEnable = 0;
    waitRx(base + 1);
    cyc(12*TICKDIV);
    check(rxCount == base + 1, "R7 no frame after disable", rxCount, base + 1);
    check(txBusy == 0 && bufFull == 1, "R7 frame finished, byte waits", {txBusy,bufFull}, 2'b01);
    expQ.push_back(8'h81);
    txEnable = 1;
    waitRx(base + 2);
    waitIdle();

    // R9 write on the load edge
    tickOn = 0; cyc(2);
    writeByte(8'h4E); expQ.push_back(8'h4E);
    @(negedge clk); bufWrite = 1; bufData = 8'hE4; forceTick = 1;
    @(negedge clk); bufWrite = 0; forceTick = 0;
    check(txIrq == 1 && txBusy == 1, "R9 frame started", {txIrq,txBusy}, 2'b11);
    check(bufFull == 1, "R9 new byte waiting", bufFull, 1);
    expQ.push_back(8'hE4);
    base = rxCount;
    tickOn = 1;
    waitRx(base + 2);
    waitIdle();

    // constrained random traffic
    base = rxCount;
    for (int k = 0; k < N_RANDOM; ) begin
      @(negedge clk);
      if (!bufFull && $urandom_range(0, 5) == 0) begin
        logic [7:0] d;
        d = 8'($urandom);
        writeByte(d); expQ.push_back(d); k++;
        check(bufFull == 1, "R2 random write full", bufFull, 1);
      end
    end
    waitRx(base + N_RANDOM);
    waitIdle();
    cyc(2*TICKDIV);
    check(expQ.size() == 0, "R4 all bytes sent", expQ.size(), 0);
    check(irqCount == rxCount, "R3 one irq per frame", irqCount, rxCount);
    check(txBusy == 0 && txLine == 1, "R6 final idle", {txBusy,txLine}, 2'b01);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    #(CLK_PERIOD*150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule